// File: doc/BRIEF.md
# Bus interrupt mailbox

Interrupts that reach the chip over a shared system bus each name a target CPU, a source id and two 64-bit data words. This block gives every CPU a one-deep mailbox for these arrivals. Each mailbox holds a busy flag, the source id and the two words. When an arrival is accepted, the block latches its payload, marks the mailbox busy and, one cycle later, raises a vectored interrupt towards the target CPU. The vector comes from a single register that software programs and that all CPUs share.

While a mailbox is busy, any further arrival for that CPU is refused in the same cycle through a ready-style answer. The sender must then retry. Software frees a mailbox by writing a busy register. The write can go to an indexed bank with one entry per CPU, or to a single alias address that always resolves to the mailbox of the CPU doing the write. A software write and an arrival for the same CPU in the same cycle are ordered so that the write is applied first. A read-select port brings out one mailbox's latched contents.

Top module: `bus_irq_mailbox`

## Requirements
- R1: After reset every busy flag is 0, no interrupt is posted, the shared vector is 0 and every mailbox reads back source 0 and data words 0.
- R2: A software write to offset 0x00 stores data bits 5:0 as the shared vector. Data bits above 5 are ignored, and every later post carries the stored vector.
- R3: A software write to an address in the busy bank (base 0x40, one 8-byte entry per CPU, index = (address - 0x40) >> 3, low three address bits ignored) sets that CPU's busy flag to data bit 5. All other data bits are ignored.
- R4: A software write to the alias offset 0x80 sets the busy flag of the CPU named on the writer-id input to data bit 5, and leaves every other flag alone.
- R5: An arrival for a CPU whose busy flag is set is refused: ready stays low, that mailbox's contents are unchanged and nothing is posted.
- R6: An arrival for a CPU whose mailbox is free is accepted in the same cycle (ready high). After the next clock edge the busy flag is set and the mailbox holds the arrival's source id and both data words.
- R7: One cycle after an acceptance, the post output pulses for exactly one cycle with the target CPU and the vector that was stored in the acceptance cycle. A vector write in that same cycle affects only later posts.
- R8: A busy write and an arrival for the same CPU in the same cycle act as if the write came first. A write that clears the flag lets the arrival be accepted, and a write that sets the flag makes the arrival be refused.
- R9: A software write to any other address, including bank indices at or beyond the CPU count (0x60 for four CPUs), changes no flag, no mailbox and no vector.
- R10: Ready is low in every cycle in which no arrival is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_addr | input | ADDR_W | Write byte offset |
| sw_wr_data | input | 64 | Write data |
| sw_wr_cpu | input | CPU_W | Id of the CPU issuing the write (used by the alias) |
| bus_irq_valid | input | 1 | Arrival presented |
| bus_irq_cpu | input | CPU_W | Target CPU of the arrival |
| bus_irq_src | input | SRC_W | Source id of the arrival |
| bus_irq_d0 | input | DATA_W | First data word |
| bus_irq_d1 | input | DATA_W | Second data word |
| bus_irq_ready | output | 1 | Arrival accepted this cycle (low means refused) |
| post_valid | output | 1 | One-cycle vectored interrupt pulse |
| post_cpu | output | CPU_W | CPU the interrupt is posted to |
| post_vec | output | 6 | Vector of the posted interrupt |
| busy_flags | output | NUM_CPU | Current busy flag of every mailbox |
| mbx_sel | input | CPU_W | Mailbox selected for read-back |
| mbx_src | output | SRC_W | Latched source id of the selected mailbox |
| mbx_d0 | output | DATA_W | Latched first word of the selected mailbox |
| mbx_d1 | output | DATA_W | Latched second word of the selected mailbox |

## Verification
The bench sweeps all 64 vector values, every bank entry with each of its eight byte offsets, and the alias from every writer. It also drives a same-cycle busy write and arrival in both directions. A design that let the arrival win the collision would either leave the mailbox stuck refusing or accept data into a mailbox software had just claimed. A design that posted the freshly written vector would show the wrong vector in the collision cycle. Refused arrivals carry a payload that differs from the latched one, so a mailbox that latches on refusal shows up at read-back. Out-of-range bank offsets and stray addresses catch decoders that alias the index.

// File: rtl/mbx_pkg.sv
// Package: shared constants and types for the bus interrupt mailbox.
// Assumes: data-bit positions are fixed by the software register contract.
package mbx_pkg;
    // Data bit that carries the busy flag in busy-register writes
    localparam int unsigned BUSY_BIT = 5;
    // Width of the shared interrupt vector (data bits VEC_W-1:0)
    localparam int unsigned VEC_W = 6;

    // Kind of software write after address decode
    typedef enum logic [1:0] {
        WR_NONE      = 2'd0,
        WR_VECTOR    = 2'd1,
        WR_BUSY_IDX  = 2'd2,
        WR_BUSY_SELF = 2'd3
    } wr_kind_e;
endpackage

// File: rtl/mbx_swdec.sv
// Module: mbx_swdec
// Decodes one software write into a vector update or a per-CPU busy update.
// Assumes: the vector and alias offsets lie outside the busy bank; if they
// overlap, vector wins over alias, and alias wins over bank.
module mbx_swdec
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CPU   = 4,
    parameter int unsigned CPU_W     = 2,
    parameter int unsigned ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] VEC_OFS   = 'h00,
    parameter logic [ADDR_W-1:0] BUSY_BASE = 'h40,
    parameter logic [ADDR_W-1:0] ALIAS_OFS = 'h80
) (
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [63:0]        wr_data,
    input  logic [CPU_W-1:0]   wr_cpu,
    output logic               vec_we,
    output logic [VEC_W-1:0]   vec_val,
    output logic [NUM_CPU-1:0] busy_we,
    output logic               busy_val
);
    localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(NUM_CPU * 8);

    wr_kind_e          kind;
    logic [ADDR_W-1:0] rel;
    logic [ADDR_W-1:0] rel_idx;
    logic              in_bank;
    logic              data_unused;

    // Offset into the busy bank and the entry index it selects
    always_comb begin
        rel     = wr_addr - BUSY_BASE;
        rel_idx = rel >> 3;
        in_bank = (wr_addr >= BUSY_BASE) && ({1'b0, rel} < SPAN);
    end

    // Classify the write by address
    always_comb begin
        kind = WR_NONE;
        if (wr_en) begin
            if (wr_addr == VEC_OFS)        kind = WR_VECTOR;
            else if (wr_addr == ALIAS_OFS) kind = WR_BUSY_SELF;
            else if (in_bank)              kind = WR_BUSY_IDX;
        end
    end

    // Field extraction from the write data
    assign vec_we   = (kind == WR_VECTOR);
    assign vec_val  = wr_data[VEC_W-1:0];
    assign busy_val = wr_data[BUSY_BIT];
    assign data_unused = ^{wr_data[63:BUSY_BIT+1]};

    // One write-enable per CPU slot
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_we
        assign busy_we[i] = ((kind == WR_BUSY_IDX)  && (rel_idx == ADDR_W'(i))) ||
                            ((kind == WR_BUSY_SELF) && (wr_cpu  == CPU_W'(i)));
    end
endmodule

// File: rtl/mbx_slot.sv
// Module: mbx_slot
// One CPU's mailbox: busy flag plus latched source id and two data words.
// Assumes: acc is only raised when busy_eff is low (the acceptor ensures it).
module mbx_slot #(
    parameter int unsigned SRC_W  = 5,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic              sw_val,
    input  logic              acc,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [DATA_W-1:0] in_d0,
    input  logic [DATA_W-1:0] in_d1,
    output logic              busy_eff,
    output logic              busy_q,
    output logic [SRC_W-1:0]  src_q,
    output logic [DATA_W-1:0] d0_q,
    output logic [DATA_W-1:0] d1_q
);
    // Busy as seen by an arrival: a same-cycle software write is applied first
    assign busy_eff = sw_we ? sw_val : busy_q;

    // Busy flag: acceptance sets it, otherwise the software-adjusted value holds
    always_ff @(posedge clk) begin
        if (!rst_n)   busy_q <= 1'b0;
        else if (acc) busy_q <= 1'b1;
        else          busy_q <= busy_eff;
    end

    // Payload latch on acceptance only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            d0_q  <= '0;
            d1_q  <= '0;
        end else if (acc) begin
            src_q <= in_src;
            d0_q  <= in_d0;
            d1_q  <= in_d1;
        end
    end
endmodule

// File: rtl/mbx_accept.sv
// Module: mbx_accept
// Same-cycle accept/refuse decision for an arriving bus interrupt.
// Assumes: busy_eff already includes any same-cycle software write.
module mbx_accept #(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned CPU_W   = 2
) (
    input  logic               valid,
    input  logic [CPU_W-1:0]   cpu,
    input  logic [NUM_CPU-1:0] busy_eff,
    output logic               ready,
    output logic [NUM_CPU-1:0] acc
);
    localparam logic [CPU_W:0] NCPU = (CPU_W+1)'(NUM_CPU);

    logic [NUM_CPU-1:0] hit;
    logic               in_range;
    logic               tgt_busy;

    // Decode the target into a one-hot slot select
    for (genvar i = 0; i < NUM_CPU; i++) begin : g_hit
        assign hit[i] = (cpu == CPU_W'(i));
    end

    // Accept when a valid arrival targets an existing, free slot
    always_comb begin
        in_range = ({1'b0, cpu} < NCPU);
        tgt_busy = |(hit & busy_eff);
        ready    = valid && in_range && !tgt_busy;
        acc      = ready ? hit : '0;
    end
endmodule

// File: rtl/mbx_post.sv
// Module: mbx_post
// Holds the shared vector and emits the registered vectored-interrupt pulse.
// Assumes: at most one acceptance per cycle.
module mbx_post
    import mbx_pkg::*;
#(
    parameter int unsigned CPU_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vec_we,
    input  logic [VEC_W-1:0] vec_val,
    input  logic             acc_any,
    input  logic [CPU_W-1:0] acc_cpu,
    output logic             post_valid,
    output logic [CPU_W-1:0] post_cpu,
    output logic [VEC_W-1:0] post_vec
);
    logic [VEC_W-1:0] vec_q;

    // Shared vector register
    always_ff @(posedge clk) begin
        if (!rst_n)      vec_q <= '0;
        else if (vec_we) vec_q <= vec_val;
    end

    // Post pulse carries the vector held in the acceptance cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_valid <= 1'b0;
            post_cpu   <= '0;
            post_vec   <= '0;
        end else begin
            post_valid <= acc_any;
            if (acc_any) begin
                post_cpu <= acc_cpu;
                post_vec <= vec_q;
            end
        end
    end
endmodule

// File: rtl/bus_irq_mailbox.sv
// Module: bus_irq_mailbox (top)
// Per-CPU mailboxes for bus interrupts with a busy handshake, an indexed and
// a self-alias busy register, and one shared interrupt vector.
// Assumes: one software write and one arrival at most per cycle.
module bus_irq_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned SRC_W   = 5,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_wr_en,
    input  logic [ADDR_W-1:0]  sw_wr_addr,
    input  logic [63:0]        sw_wr_data,
    input  logic [CPU_W-1:0]   sw_wr_cpu,
    input  logic               bus_irq_valid,
    input  logic [CPU_W-1:0]   bus_irq_cpu,
    input  logic [SRC_W-1:0]   bus_irq_src,
    input  logic [DATA_W-1:0]  bus_irq_d0,
    input  logic [DATA_W-1:0]  bus_irq_d1,
    output logic               bus_irq_ready,
    output logic               post_valid,
    output logic [CPU_W-1:0]   post_cpu,
    output logic [VEC_W-1:0]   post_vec,
    output logic [NUM_CPU-1:0] busy_flags,
    input  logic [CPU_W-1:0]   mbx_sel,
    output logic [SRC_W-1:0]   mbx_src,
    output logic [DATA_W-1:0]  mbx_d0,
    output logic [DATA_W-1:0]  mbx_d1
);
    logic               vec_we;
    logic [VEC_W-1:0]   vec_val;
    logic [NUM_CPU-1:0] busy_we;
    logic               busy_val;
    logic [NUM_CPU-1:0] busy_eff;
    logic [NUM_CPU-1:0] acc;
    logic [SRC_W-1:0]   src_q [NUM_CPU];
    logic [DATA_W-1:0]  d0_q  [NUM_CPU];
    logic [DATA_W-1:0]  d1_q  [NUM_CPU];

    mbx_swdec #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W),
        .ADDR_W  (ADDR_W)
    ) u_swdec (
        .wr_en    (sw_wr_en),
        .wr_addr  (sw_wr_addr),
        .wr_data  (sw_wr_data),
        .wr_cpu   (sw_wr_cpu),
        .vec_we   (vec_we),
        .vec_val  (vec_val),
        .busy_we  (busy_we),
        .busy_val (busy_val)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
        mbx_slot #(
            .SRC_W  (SRC_W),
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_we    (busy_we[i]),
            .sw_val   (busy_val),
            .acc      (acc[i]),
            .in_src   (bus_irq_src),
            .in_d0    (bus_irq_d0),
            .in_d1    (bus_irq_d1),
            .busy_eff (busy_eff[i]),
            .busy_q   (busy_flags[i]),
            .src_q    (src_q[i]),
            .d0_q     (d0_q[i]),
            .d1_q     (d1_q[i])
        );
    end

    mbx_accept #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_accept (
        .valid    (bus_irq_valid),
        .cpu      (bus_irq_cpu),
        .busy_eff (busy_eff),
        .ready    (bus_irq_ready),
        .acc      (acc)
    );

    mbx_post #(
        .CPU_W (CPU_W)
    ) u_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .vec_we     (vec_we),
        .vec_val    (vec_val),
        .acc_any    (bus_irq_ready),
        .acc_cpu    (bus_irq_cpu),
        .post_valid (post_valid),
        .post_cpu   (post_cpu),
        .post_vec   (post_vec)
    );

    // Read-back mux for one selected mailbox
    always_comb begin
        mbx_src = '0;
        mbx_d0  = '0;
        mbx_d1  = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (mbx_sel == CPU_W'(i)) begin
                mbx_src = src_q[i];
                mbx_d0  = d0_q[i];
                mbx_d1  = d1_q[i];
            end
        end
    end
endmodule

// File: rtl/mbx_checker.sv
// Module: mbx_checker
// Temporal checks on the mailbox ports, bound into every bus_irq_mailbox.
module mbx_checker #(
    parameter int unsigned NUM_CPU = 4,
    parameter int unsigned CPU_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sw_wr_en,
    input logic               bus_irq_valid,
    input logic [CPU_W-1:0]   bus_irq_cpu,
    input logic               bus_irq_ready,
    input logic               post_valid,
    input logic [CPU_W-1:0]   post_cpu,
    input logic [NUM_CPU-1:0] busy_flags
);
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_irq_valid |-> !bus_irq_ready); // R10

    AST_REFUSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_irq_valid && !sw_wr_en && busy_flags[bus_irq_cpu]) |-> !bus_irq_ready); // R5

    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_irq_valid && bus_irq_ready) |=> busy_flags[$past(bus_irq_cpu)]); // R6

    AST_POST_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_irq_valid && bus_irq_ready) |=> (post_valid && post_cpu == $past(bus_irq_cpu))); // R7

    AST_POST_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |-> $past(bus_irq_valid && bus_irq_ready)); // R7

    AST_QUIET_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_wr_en && !(bus_irq_valid && bus_irq_ready)) |=> $stable(busy_flags)); // R9
endmodule

bind bus_irq_mailbox mbx_checker #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
) u_mbx_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_wr_en      (sw_wr_en),
    .bus_irq_valid (bus_irq_valid),
    .bus_irq_cpu   (bus_irq_cpu),
    .bus_irq_ready (bus_irq_ready),
    .post_valid    (post_valid),
    .post_cpu      (post_cpu),
    .busy_flags    (busy_flags)
);

// File: tb/test_bus_irq_mailbox.sv
// Bench: per-cycle reference model of the mailbox, driven through sweeps.
module test_bus_irq_mailbox;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [7:0]  sw_wr_addr = '0;
    logic [63:0] sw_wr_data = '0;
    logic [1:0]  sw_wr_cpu = '0;
    logic        bus_irq_valid = 1'b0;
    logic [1:0]  bus_irq_cpu = '0;
    logic [4:0]  bus_irq_src = '0;
    logic [63:0] bus_irq_d0 = '0;
    logic [63:0] bus_irq_d1 = '0;
    logic        bus_irq_ready;
    logic        post_valid;
    logic [1:0]  post_cpu;
    logic [5:0]  post_vec;
    logic [3:0]  busy_flags;
    logic [1:0]  mbx_sel = '0;
    logic [4:0]  mbx_src;
    logic [63:0] mbx_d0;
    logic [63:0] mbx_d1;

    int total = 0;
    int bad = 0;

    // Reference state
    logic [3:0]  m_busy = '0;
    logic [5:0]  m_vec = '0;
    logic [4:0]  m_src [4];
    logic [63:0] m_d0  [4];
    logic [63:0] m_d1  [4];

    bus_irq_mailbox i_bus_irq_mailbox (.*);

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
        end
    endtask

    // One cycle of stimulus with the expected response worked out from the model
    task automatic cyc(input string tag, input bit we, input logic [7:0] a,
                       input logic [63:0] d, input logic [1:0] wc, input bit v,
                       input logic [1:0] c, input logic [4:0] s,
                       input logic [63:0] x0, input logic [63:0] x1);
        logic [3:0] nb;
        logic [5:0] nv;
        logic       er;
        @(negedge clk);
        sw_wr_en = we; sw_wr_addr = a; sw_wr_data = d; sw_wr_cpu = wc;
        bus_irq_valid = v; bus_irq_cpu = c; bus_irq_src = s;
        bus_irq_d0 = x0; bus_irq_d1 = x1; mbx_sel = c;
        nb = m_busy;
        nv = m_vec;
        if (we) begin
            if (a == 8'h00)                      nv = d[5:0];
            else if (a == 8'h80)                 nb[wc] = d[5];
            else if (a >= 8'h40 && a < 8'h60)    nb[(a - 8'h40) >> 3] = d[5];
        end
        er = v && !nb[c];
        #1;
        check(tag, "ready", 64'(bus_irq_ready), 64'(er));
        if (er) begin
            nb[c] = 1'b1;
            m_src[c] = s; m_d0[c] = x0; m_d1[c] = x1;
        end
        @(posedge clk);
        #1;
        check(tag, "busy", 64'(busy_flags), 64'(nb));
        check(tag, "post", 64'({post_valid, (post_valid ? {post_cpu, post_vec} : 8'h00)}),
              64'({er, (er ? {c, m_vec} : 8'h00)}));
        check(tag, "mailbox", 64'(mbx_src) ^ mbx_d0 ^ {mbx_d1[31:0], mbx_d1[63:32]},
              64'(m_src[c]) ^ m_d0[c] ^ {m_d1[c][31:0], m_d1[c][63:32]});
        m_busy = nb;
        m_vec  = nv;
    endtask

    task automatic idle(input string tag);
        cyc(tag, 0, 8'h00, 64'h0, 2'd0, 0, 2'd0, 5'd0, 64'h0, 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_src[i] = '0; m_d0[i] = '0; m_d1[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state, R10 ready low without an arrival
        check("R1", "busy", 64'(busy_flags), 64'h0);
        check("R1", "post", 64'(post_valid), 64'h0);
        check("R10", "ready", 64'(bus_irq_ready), 64'h0);
        for (int i = 0; i < 4; i++) begin
            mbx_sel = 2'(i);
            #1;
            check("R1", "mbx", 64'(mbx_src) | mbx_d0 | mbx_d1, 64'h0);
        end
        // R1: first post before any vector write carries vector 0
        cyc("R1", 0, 8'h00, 64'h0, 2'd0, 1, 2'd2, 5'd7, 64'h11, 64'h22);
        cyc("R3", 1, 8'h50, 64'h0, 2'd0, 0, 2'd2, 5'd0, 64'h0, 64'h0);

        // R2 / R6 / R7: sweep every vector value
        for (int vv = 0; vv < 64; vv++) begin
            logic [1:0] t;
            t = 2'(vv);
            cyc("R2", 1, 8'h00, {58'h2AAAAAAAAAAAAAA, 6'(vv)}, 2'd0, 0, 2'd0, 5'd0, 64'h0, 64'h0);
            cyc("R6", 0, 8'h00, 64'h0, 2'd0, 1, t, 5'(vv * 3),
                64'(vv) * 64'h0101_0101_0101_0101, ~(64'(vv) << 7));
            cyc("R3", 1, 8'h40 + 8'(t) * 8'd8, 64'hFFFF_FFFF_FFFF_FFDF, 2'd0, 0, t, 5'd0, 64'h0, 64'h0);
        end

        // R3: every bank entry at each of its byte offsets
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 8; k++) begin
                cyc("R3", 1, 8'h40 + 8'(c * 8 + k), 64'hC000_0000_0000_0020 | 64'(k), 2'd0,
                    0, 2'(c), 5'd0, 64'h0, 64'h0);
                cyc("R3", 1, 8'h40 + 8'(c * 8 + k), 64'hFFFF_FFFF_FFFF_FFDF, 2'd0,
                    0, 2'(c), 5'd0, 64'h0, 64'h0);
            end
        end

        // R4: alias from every writer
        for (int w = 0; w < 4; w++) begin
            cyc("R4", 1, 8'h80, 64'h20, 2'(w), 0, 2'(w), 5'd0, 64'h0, 64'h0);
            cyc("R4", 1, 8'h80, 64'h0F, 2'(w), 0, 2'(w), 5'd0, 64'h0, 64'h0);
        end

        // R5: refuse while busy, mailbox keeps first payload
        cyc("R6", 0, 8'h00, 64'h0, 2'd0, 1, 2'd1, 5'd9, 64'hAAAA, 64'hBBBB);
        cyc("R5", 0, 8'h00, 64'h0, 2'd0, 1, 2'd1, 5'd30, 64'hDEAD, 64'hBEEF);
        cyc("R5", 1, 8'h48, 64'h20, 2'd0, 0, 2'd1, 5'd0, 64'h0, 64'h0);
        cyc("R5", 0, 8'h00, 64'h0, 2'd0, 1, 2'd1, 5'd31, 64'h1234, 64'h5678);

        // R8: same-cycle clear lets the arrival in; same-cycle set keeps it out
        cyc("R8", 1, 8'h48, 64'h0, 2'd0, 1, 2'd1, 5'd4, 64'hCAFE, 64'hF00D);
        cyc("R8", 1, 8'h80, 64'h20, 2'd3, 1, 2'd3, 5'd5, 64'h77, 64'h88);
        cyc("R8", 1, 8'h80, 64'h00, 2'd1, 1, 2'd1, 5'd6, 64'h99, 64'hAA);

        // R7: vector write in the acceptance cycle affects only later posts
        cyc("R7", 1, 8'h00, 64'h3C, 2'd0, 1, 2'd0, 5'd1, 64'h5, 64'h6);
        cyc("R7", 1, 8'h40, 64'h0, 2'd0, 0, 2'd0, 5'd0, 64'h0, 64'h0);
        cyc("R7", 0, 8'h00, 64'h0, 2'd0, 1, 2'd0, 5'd2, 64'h7, 64'h8);

        // R9: stray addresses, out-of-range bank index
        cyc("R9", 1, 8'h60, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 0, 2'd2, 5'd0, 64'h0, 64'h0);
        cyc("R9", 1, 8'h08, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 0, 2'd2, 5'd0, 64'h0, 64'h0);
        cyc("R9", 1, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 0, 2'd2, 5'd0, 64'h0, 64'h0);
        cyc("R9", 1, 8'h3F, 64'hFFFF_FFFF_FFFF_FFFF, 2'd2, 1, 2'd2, 5'd3, 64'h1, 64'h2);

        // R10: ready low when nothing is presented
        idle("R10");
        idle("R10");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule